// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Bank

This block is a memory-mapped bank of five down-counting timer channels. The counter width is set by one parameter, 16 or 32 bits. Two 8-bit prescalers run from the bus clock. The first one serves channels 0 and 1, and the second serves channels 2, 3 and 4. After its prescaler, each channel has its own power-of-two divider. The result is a single-cycle tick for every channel, and a channel counts only on its own tick.

Software configures a channel in three steps. It writes the channel's count buffer. It then pulses the channel's manual-update bit, which copies the buffer into the live counter. Finally it sets the start bit, with or without auto-reload. With auto-reload set, the channel runs periodically. Without it, the channel stops after one pass.

When a channel counts past zero, it raises a pending flag. Pending flags are cleared by writing a one to them. The interrupt line is the OR of the pending flags whose enable bits are set. Bus access is a write strobe with a byte offset. Reads are combinational from the offset.

Top module: `ptmr_top`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low. Any offset outside the register map reads zero.
- R2: Readback widths:
  - Offset 0x00 holds two prescaler fields and reads back bits [15:0].
  - Offset 0x04 holds five 4-bit divider selects and reads back bits [19:0].
  - Count buffers at 0x0C+12n (n = 0..4) read back their CNT_W low bits.
  - Compare buffers at 0x10+12n (n = 0..3) read back their CNT_W low bits.
- R3: While a channel's manual-update bit is set, its live counter takes the count-buffer value and holds it, even when start is also set. The live counter reads at 0x14+12n for channels 0..3 and at 0x40 for channel 4.
- R4: A channel's counter decrements by exactly one on each of its ticks while start is 1 and manual update is 0. It holds its value when start is 0.
- R5: The tick period of channel n is (P+1)·2^S bus cycles.
  - P is field [7:0] of offset 0x00 for channels 0 and 1, and field [15:8] for channels 2 to 4.
  - S is the divider select at bits [4n+3:4n] of offset 0x04.
- R6: With auto-reload set, a channel whose count buffer holds N reaches zero every N+1 ticks and reloads N from its buffer.
- R7: With auto-reload clear, a channel stops at zero after raising its pending flag once. It stays at zero with no further pending flag until the next manual update.
- R8: Interrupt register at 0x44:
  - Bit n enables channel n.
  - Bit n+5 is the pending flag of channel n, set on the tick where the counter passes from zero.
  - Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when some channel has both its enable bit and its pending bit set.
- R10: The control register at 0x08 holds four bits per group: start (bit 0), manual update (bit 1), invert (bit 2) and auto-reload (bit 3).
  - Channel 0 uses group 0 and channel k>0 uses group k+1, so channel 4 uses bits [23:20].
  - Group 1 (bits [7:4]) is reserved: it reads zero and drives no channel.
- R11: Divider select codes above 4 divide by 16, the same as code 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock; also the timer base clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | OR of enabled pending flags |

## Verification
The bench sweeps every channel across several prescaler values and divider codes, including a code above 4. In each case it measures the cycle distance between two consecutive pending events. The two prescaler fields are given different values, so a channel wired to the wrong prescaler shows a wrong period. A divider that treats codes above 4 as larger powers also shows a wrong period, as does a reload that is off by one tick.

One-shot mode is checked by waiting well past the first expiry. A design that keeps counting or re-arms would raise a second pending flag. The reserved control group is written with all ones. A design that maps channel 1 to group 1 would start counting from that write. Other checks look for specific failures:
- The manual-update hold catches a counter that decrements while loading.
- The zero-write to the interrupt register catches pending bits cleared on 0 instead of on 1.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int NUM_CH    = 5;
    localparam int SEL_W     = 4;
    localparam int MAX_SEL   = 4;
    localparam int GRP_W     = 4;

    localparam logic [7:0] OFF_PSC  = 8'h00;
    localparam logic [7:0] OFF_DIV  = 8'h04;
    localparam logic [7:0] OFF_CTRL = 8'h08;
    localparam logic [7:0] OFF_OBS4 = 8'h40;
    localparam logic [7:0] OFF_INTR = 8'h44;
    localparam int         PEND_LSB = NUM_CH;

    // bit order inside one control group
    typedef struct packed {
        logic reload;
        logic invert;
        logic manual;
        logic start;
    } grp_ctrl_t;

    function automatic int grp_lsb(input int ch);
        return (ch == 0) ? 0 : GRP_W * (ch + 1);
    endfunction

    function automatic logic [7:0] cntb_off(input int ch);
        return 8'(12 + 12 * ch);
    endfunction

    function automatic logic [7:0] cmpb_off(input int ch);
        return 8'(16 + 12 * ch);
    endfunction

    function automatic logic [7:0] obs_off(input int ch);
        return (ch < NUM_CH - 1) ? 8'(20 + 12 * ch) : OFF_OBS4;
    endfunction

    function automatic int psc_grp(input int ch);
        return (ch < 2) ? 0 : 1;
    endfunction

endpackage

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen
    import ptmr_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [1:0][PSC_W-1:0]     psc_i,
    input  logic [NUM_CH-1:0][SEL_W-1:0] sel_i,
    output logic [NUM_CH-1:0]         tick_o
);

    localparam int DCNT_W = MAX_SEL;

    typedef struct packed {
        logic [1:0][PSC_W-1:0]  pcnt;
        logic [1:0][DCNT_W-1:0] dcnt;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic [1:0] pre_pulse;

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < 2; g++) begin
            pre_pulse[g] = (st_q.pcnt[g] >= psc_i[g]);
            if (pre_pulse[g]) begin
                st_d.pcnt[g] = '0;
                st_d.dcnt[g] = st_q.dcnt[g] + 1'b1;
            end else begin
                st_d.pcnt[g] = st_q.pcnt[g] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_div
        localparam int G = psc_grp(c);
        logic [DCNT_W-1:0] mask;
        int                sel_eff;
        always_comb begin
            sel_eff = (int'(sel_i[c]) > MAX_SEL) ? MAX_SEL : int'(sel_i[c]);
            mask    = DCNT_W'((1 << sel_eff) - 1);
            tick_o[c] = pre_pulse[G] && ((st_q.dcnt[G] & mask) == mask);
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_chk
        // prescaler pulses never come back to back unless the divide value is zero
        assert_psc_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pre_pulse[g] && psc_i[g] != '0) |=> (!pre_pulse[g] || psc_i[g] == '0));
    end

endmodule

// File: rtl/ptmr_chan.sv
module ptmr_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             manual_i,
    input  logic             reload_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] buf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      run;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        run      = start_i && !manual_i && !st_q.done;
        if (manual_i) begin
            st_d.cnt  = buf_i;
            st_d.done = 1'b0;
        end else if (run && tick_i) begin
            if (st_q.cnt == '0) begin
                expire_o = 1'b1;
                if (reload_i) st_d.cnt  = buf_i;
                else          st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    assert_manual_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        manual_i |=> (st_q.cnt == $past(buf_i)));

    assert_hold_stopped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !manual_i) |=> $stable(st_q.cnt));

    assert_step_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && tick_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    assert_one_shot_halt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.done && !manual_i) |=> ($stable(st_q.cnt) && !expire_o));

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        reg_we_i,
    input  logic [7:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        irq_o
);

    localparam int NUM_CMP = NUM_CH - 1;

    typedef struct packed {
        logic [1:0][PSC_W-1:0]        psc;
        logic [NUM_CH-1:0][SEL_W-1:0] sel;
        grp_ctrl_t [NUM_CH-1:0]       ctrl;
        logic [NUM_CH-1:0][CNT_W-1:0] cntb;
        logic [NUM_CMP-1:0][CNT_W-1:0] cmpb;
        logic [NUM_CH-1:0]            ien;
        logic [NUM_CH-1:0]            pend;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_CH-1:0]            tick;
    logic [NUM_CH-1:0]            expire;
    logic [NUM_CH-1:0][CNT_W-1:0] live_cnt;
    logic [NUM_CH-1:0]            clr_mask;
    logic                         unused_hi;

    assign unused_hi = ^reg_wdata_i[31:24];

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (reg_we_i) begin
            if (reg_addr_i == OFF_PSC) begin
                st_d.psc[0] = reg_wdata_i[PSC_W-1:0];
                st_d.psc[1] = reg_wdata_i[2*PSC_W-1:PSC_W];
            end
            if (reg_addr_i == OFF_DIV) begin
                for (int c = 0; c < NUM_CH; c++)
                    st_d.sel[c] = reg_wdata_i[SEL_W*c +: SEL_W];
            end
            if (reg_addr_i == OFF_CTRL) begin
                for (int c = 0; c < NUM_CH; c++)
                    st_d.ctrl[c] = reg_wdata_i[grp_lsb(c) +: GRP_W];
            end
            if (reg_addr_i == OFF_INTR) begin
                st_d.ien = reg_wdata_i[NUM_CH-1:0];
                clr_mask = reg_wdata_i[PEND_LSB +: NUM_CH];
            end
            for (int c = 0; c < NUM_CH; c++)
                if (reg_addr_i == cntb_off(c)) st_d.cntb[c] = reg_wdata_i[CNT_W-1:0];
            for (int c = 0; c < NUM_CMP; c++)
                if (reg_addr_i == cmpb_off(c)) st_d.cmpb[c] = reg_wdata_i[CNT_W-1:0];
        end
        // a new expiry outranks a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_mask) | expire;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == OFF_PSC) begin
            reg_rdata_o[PSC_W-1:0]       = st_q.psc[0];
            reg_rdata_o[2*PSC_W-1:PSC_W] = st_q.psc[1];
        end
        if (reg_addr_i == OFF_DIV) begin
            for (int c = 0; c < NUM_CH; c++)
                reg_rdata_o[SEL_W*c +: SEL_W] = st_q.sel[c];
        end
        if (reg_addr_i == OFF_CTRL) begin
            for (int c = 0; c < NUM_CH; c++)
                reg_rdata_o[grp_lsb(c) +: GRP_W] = st_q.ctrl[c];
        end
        if (reg_addr_i == OFF_INTR) begin
            reg_rdata_o[NUM_CH-1:0]          = st_q.ien;
            reg_rdata_o[PEND_LSB +: NUM_CH]  = st_q.pend;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr_i == cntb_off(c)) reg_rdata_o[CNT_W-1:0] = st_q.cntb[c];
            if (reg_addr_i == obs_off(c))  reg_rdata_o[CNT_W-1:0] = live_cnt[c];
        end
        for (int c = 0; c < NUM_CMP; c++)
            if (reg_addr_i == cmpb_off(c)) reg_rdata_o[CNT_W-1:0] = st_q.cmpb[c];
    end

    assign irq_o = |(st_q.ien & st_q.pend);

    ptmr_tick_gen #(
        .PSC_W (PSC_W)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .psc_i  (st_q.psc),
        .sel_i  (st_q.sel),
        .tick_o (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ptmr_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .start_i  (st_q.ctrl[c].start),
            .manual_i (st_q.ctrl[c].manual),
            .reload_i (st_q.ctrl[c].reload),
            .tick_i   (tick[c]),
            .buf_i    (st_q.cntb[c]),
            .cnt_o    (live_cnt[c]),
            .expire_o (expire[c])
        );

        assert_pend_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            expire[c] |=> st_q.pend[c]);

        assert_pend_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (reg_we_i && reg_addr_i == OFF_INTR && reg_wdata_i[PEND_LSB + c] && !expire[c])
            |=> !st_q.pend[c]);

        assert_pend_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.pend[c] && !(reg_we_i && reg_addr_i == OFF_INTR && reg_wdata_i[PEND_LSB + c]))
            |=> st_q.pend[c]);
    end

endmodule

// File: tb/ptmr_top_test.sv
module ptmr_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptmr_top uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [7:0] cntb_a(input int ch);  return 8'(12 + 12 * ch); endfunction
    function automatic logic [7:0] obs_a(input int ch);   return (ch < 4) ? 8'(20 + 12 * ch) : 8'h40; endfunction
    function automatic int         grp_a(input int ch);   return (ch == 0) ? 0 : 4 * (ch + 1); endfunction

    // waits until pending bit of ch is seen; returns cycle stamp or -1
    task automatic wait_pend(input int ch, output int stamp);
        logic [31:0] v;
        stamp = -1;
        for (int i = 0; i < 4000; i++) begin
            rd(8'h44, v);
            if (v[5 + ch]) begin
                stamp = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        foreach (v[i]) ;
        for (int a = 0; a < 8'h48; a += 4) begin
            rd(8'(a), v);
            check("R1 reset read", v, 0);
        end
        rd(8'h48, v); check("R1 unmapped 0x48", v, 0);
        rd(8'h80, v); check("R1 unmapped 0x80", v, 0);
        check("R1 irq low", {31'b0, irq}, 0);

        // R2 / R10 readback widths
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 prescaler field", v, 32'h0000_FFFF);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R2 divider selects", v, 32'h000F_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); check("R2 count buffer", v, 32'h0000_FFFF);
        wr(8'h34, 32'h1234_5678); rd(8'h34, v); check("R2 compare buffer", v, 32'h0000_5678);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check("R10 control groups", v, 32'h00FF_FF0F);
        wr(8'h08, 0); wr(8'h00, 0); wr(8'h04, 0);

        // R3 manual update holds the buffer value even with start set
        wr(cntb_a(0), 77);
        wr(8'h08, 32'h3);
        repeat (5) @(negedge clk);
        rd(obs_a(0), v); check("R3 manual load holds", v, 77);
        wr(8'h08, 0);

        // R4 decrement per tick, hold when stopped
        wr(cntb_a(3), 1000);
        wr(8'h08, 32'h2 << grp_a(3));
        wr(8'h08, 32'h1 << grp_a(3));
        rd(obs_a(3), v);
        repeat (10) @(negedge clk);
        rd(obs_a(3), v2); check("R4 ten ticks ten steps", v - v2, 10);
        wr(8'h08, 0);
        rd(obs_a(3), v);
        repeat (10) @(negedge clk);
        rd(obs_a(3), v2); check("R4 hold when stopped", v2, v);

        // R10 reserved group drives nothing
        wr(cntb_a(1), 50);
        wr(8'h08, 32'h2 << grp_a(1));
        wr(8'h08, 0);
        wr(8'h08, 32'h0000_00F0);
        repeat (20) @(negedge clk);
        rd(obs_a(1), v); check("R10 reserved group no start", v, 50);
        rd(8'h08, v);    check("R10 reserved group reads zero", v, 0);
        wr(8'h08, 0);

        // R7 one-shot, R8 pending, R9 irq
        wr(cntb_a(2), 4);
        wr(8'h08, 32'h2 << grp_a(2));
        wr(8'h44, 32'h3E0);
        wr(8'h08, 32'h1 << grp_a(2));
        wait_pend(2, t1);
        check("R8 pending set on expiry", {31'b0, t1 >= 0}, 1);
        rd(obs_a(2), v); check("R7 one-shot stops at zero", v, 0);
        check("R9 irq masked", {31'b0, irq}, 0);
        wr(8'h44, 32'h004);
        rd(8'h44, v); check("R8 write zero keeps pending", v, 32'h084);
        check("R9 irq enabled", {31'b0, irq}, 1);
        wr(8'h44, 32'h084);
        check("R9 irq after clear", {31'b0, irq}, 0);
        repeat (40) @(negedge clk);
        rd(8'h44, v); check("R7 no second pending", v, 32'h004);
        rd(obs_a(2), v); check("R7 stays at zero", v, 0);
        wr(8'h08, 0); wr(8'h44, 0);

        // R5 R6 R11 period sweep
        for (int ch = 0; ch < 5; ch++) begin
            for (int pa = 0; pa <= 2; pa += 2) begin
                for (int di = 0; di < 4; di++) begin
                    int d, s, p, expv;
                    d = (di == 3) ? 7 : di;
                    s = (d > 4) ? 4 : d;
                    p = (ch < 2) ? pa : pa + 1;
                    expv = 3 * (p + 1) * (1 << s);
                    wr(8'h00, 32'((pa + 1) << 8 | pa));
                    wr(8'h04, {12'b0, {5{4'(d)}}});
                    wr(cntb_a(ch), 2);
                    wr(8'h08, 32'h2 << grp_a(ch));
                    wr(8'h44, 32'h3E0);
                    wr(8'h08, 32'h9 << grp_a(ch));
                    wait_pend(ch, t1);
                    wr(8'h44, 32'(1 << (5 + ch)));
                    wait_pend(ch, t2);
                    if (d > 4)
                        check($sformatf("R11 ch%0d period psc%0d code%0d", ch, p, d), 32'(t2 - t1), 32'(expv));
                    else
                        check($sformatf("R5 R6 ch%0d period psc%0d code%0d", ch, p, d), 32'(t2 - t1), 32'(expv));
                    wr(8'h08, 0);
                end
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule